// File: doc/BRIEF.md
# Synchronous answer-to-reset serializer

This block streams a fixed identification word out of a serial memory's data pin when the host holds the card reset line high across one serial clock pulse. The word comes in as a parallel value. The block sends it one bit per serial clock pulse, byte by byte and least significant bit first. It drives the open-drain data pad only by pulling it low. In the same cycle that the reset pulse is recognised, it emits a single-cycle pulse that wipes every password and authentication privilege held elsewhere in the device.

The block also decides who owns the data line. While it is idle, it grants the line to the two-wire command engine. When a reset pulse is seen, it withdraws that grant at once, which aborts any command in flight. It returns the grant only when the stream has finished. The pad inputs are asynchronous and are brought into the system clock domain by a synchronizer chain of configurable depth.

The controller has three states:

- `ST_IDLE`: the line is released and the two-wire engine owns the bus.
- `ST_HOLD`: a reset pulse has been seen, and the block waits for the reset line to fall.
- `ST_SEND`: the block is shifting bits out.

The transitions are as follows:

- IDLE→HOLD: the reset line is high at a serial clock rising edge.
- HOLD→SEND: the reset line has fallen, and the index is loaded with 0.
- SEND→SEND (advance): a serial clock falling edge arrives while the bit is not the last one.
- SEND→IDLE: a serial clock falling edge arrives after the last bit.
- SEND→HOLD (restart): the reset line is high at a serial clock rising edge during the stream.

Top module: `atr_serializer`

## Requirements
- R1: A serial clock rising edge seen while `card_rst` is high raises `priv_clear` for exactly one clock cycle. This happens once per reset pulse, taken from idle or from an active stream.
- R2: Holding `card_rst` high with no serial clock rising edge starts nothing. `priv_clear` stays 0, `sda_oe` stays 0 and `twi_enable` stays 1.
- R3: Once `card_rst` falls after a reset pulse, bit 0 of `atr_word` is on the line before the next serial clock rising edge.
- R4: Each serial clock falling edge moves to the next bit, so the host reads `atr_word[0]` through `atr_word[31]` in that order on 32 rising edges. A bit value of 0 is sent as `sda_oe`=1 (line pulled low), and a bit value of 1 is sent as `sda_oe`=0 (line released).
- R5: The falling edge after the 32nd rising edge releases the line (`sda_oe`=0) and returns the block to idle. Further serial clock pulses without reset leave the line released.
- R6: `twi_enable` is 0 from the reset pulse until the stream ends, and `sda_oe` is never 1 while `twi_enable` is 1.
- R7: A new reset pulse during a stream aborts it, and the next stream starts again at bit 0.
- R8: Serial clock pulses that occur while `card_rst` is still high after the reset pulse neither advance the stream nor raise `priv_clear` again.
- R9: After system reset, `sda_oe`=0, `priv_clear`=0 and `twi_enable`=1.
- R10: With the default word 32'hA055AA2C, the line carries the bytes 0x2C, 0xAA, 0x55 and 0xA0 in that order, each least significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| card_rst | input | 1 | Card reset pin level (asynchronous) |
| scl | input | 1 | Serial clock pin level (asynchronous) |
| atr_word | input | WORD_W | Identification word; bit 0 is sent first |
| sda_oe | output | 1 | 1 pulls the open-drain data pad low |
| priv_clear | output | 1 | One-cycle pulse that revokes all access privileges |
| twi_enable | output | 1 | 1 while the two-wire engine may own the data line |

## Verification
The bench targets the following corner cases:

- **Reset level without a clock pulse.** A design that reacted to the level alone would clear privileges and seize the bus.
- **Extra clock pulses while reset is still high.** An early shift would drop bit 0, and a repeated clear pulse would show up as an extra count.
- **Restart in the middle of a stream.** A design that kept the old index would resume partway through the word.
- **The 32nd falling edge.** An off-by-one would either leave the pad driven or cut the last bit.
- **Words such as all-ones and all-zeros.** These catch a polarity or bit-order error on the open-drain output.

// File: rtl/atr_pkg.sv
`timescale 1ns/1ps
package atr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_SEND = 2'd2
    } atr_state_e;

    localparam logic [31:0] ATR_DEFAULT_WORD = 32'hA055AA2C;
endpackage

// File: rtl/atr_pin_sync.sv
`timescale 1ns/1ps
module atr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pin_s
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b0;
                else        q <= pin;
            end
            assign pin_s = q;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], pin};
            end
            assign pin_s = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/atr_edge_det.sv
`timescale 1ns/1ps
module atr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;
    assign fall = ~level & level_d;
endmodule

// File: rtl/atr_bit_index.sv
`timescale 1ns/1ps
module atr_bit_index #(
    parameter int WORD_W = 32,
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [CNT_W-1:0] idx,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= '0;
        else if (adv)  idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);

    AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(idx)); // R8
endmodule

// File: rtl/atr_ctrl.sv
`timescale 1ns/1ps
module atr_ctrl
    import atr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       card_rst_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       last,
    output atr_state_e state,
    output logic       load,
    output logic       adv,
    output logic       priv_clear
);
    atr_state_e state_nx;
    logic       rst_hit;

    assign rst_hit = card_rst_s & scl_rise;

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        adv      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rst_hit) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (!card_rst_s) begin
                    state_nx = ST_SEND;
                    load     = 1'b1;
                end
            end
            ST_SEND: begin
                if (rst_hit) begin
                    state_nx = ST_HOLD;
                end else if (scl_fall) begin
                    if (last) state_nx = ST_IDLE;
                    else      adv      = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) priv_clear <= 1'b0;
        else        priv_clear <= rst_hit && (state != ST_HOLD);
    end

    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        priv_clear |=> !priv_clear); // R1
    AST_CLEAR_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        priv_clear |-> (state == ST_HOLD)); // R1
    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && last && scl_fall && !card_rst_s) |=> (state == ST_IDLE)); // R5
endmodule

// File: rtl/atr_serializer.sv
`timescale 1ns/1ps
module atr_serializer
    import atr_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_rst,
    input  logic              scl,
    input  logic [WORD_W-1:0] atr_word,
    output logic              sda_oe,
    output logic              priv_clear,
    output logic              twi_enable
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic             card_rst_s, scl_s, scl_rise, scl_fall;
    logic             load, adv, last;
    logic [CNT_W-1:0] idx;
    atr_state_e       state;

    atr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_rst (
        .clk(clk), .rst_n(rst_n), .pin(card_rst), .pin_s(card_rst_s));
    atr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .pin(scl), .pin_s(scl_s));

    atr_edge_det u_scl_edge (
        .clk(clk), .rst_n(rst_n), .level(scl_s), .rise(scl_rise), .fall(scl_fall));

    atr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .card_rst_s(card_rst_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .last(last),
        .state(state), .load(load), .adv(adv), .priv_clear(priv_clear));

    atr_bit_index #(.WORD_W(WORD_W)) u_index (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .idx(idx), .last(last));

    assign sda_oe     = (state == ST_SEND) && !atr_word[idx];
    assign twi_enable = (state == ST_IDLE);

    AST_NO_DRIVE_WHEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        twi_enable |-> !sda_oe); // R6
    AST_ADV_NOT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !last); // R5
endmodule

// File: tb/test_atr_serializer.sv
`timescale 1ns/1ps
module test_atr_serializer;
    import atr_pkg::*;

    typedef struct {
        logic  val;
        int    pos;
    } exp_bit_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_rst = 1'b0;
    logic        scl = 1'b0;
    logic [31:0] atr_word = ATR_DEFAULT_WORD;
    logic        sda_oe, priv_clear, twi_enable;

    int          n_checks = 0;
    int          n_errors = 0;
    int          clr_count = 0;
    int          clr_width = 0;
    string       mon_tag = "R4";
    exp_bit_t    exp_q[$];
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    atr_serializer i_atr_serializer (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .scl(scl),
        .atr_word(atr_word), .sda_oe(sda_oe), .priv_clear(priv_clear),
        .twi_enable(twi_enable));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // priv_clear pulse counter and width monitor (R1)
    always @(negedge clk) begin
        if (priv_clear) begin
            if (clr_width == 0) clr_count++;
            clr_width++;
            if (clr_width == 2) begin
                n_checks++;
                n_errors++;
                $display("FAIL R1 priv_clear width actual=2+ expected=1");
            end
        end else begin
            clr_width = 0;
        end
    end

    // scoreboard monitor: host samples the line on each SCL rising edge
    always @(posedge scl) begin
        if (exp_q.size() > 0) begin
            exp_bit_t e;
            e = exp_q.pop_front();
            check((e.pos == 0) ? "R3 first bit" : mon_tag,
                  {31'd0, ~sda_oe}, {31'd0, e.val});
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_pulse();
        scl = 1'b1; wait_clk(8);
        scl = 1'b0; wait_clk(8);
    endtask

    task automatic reset_pulse();
        card_rst = 1'b1; wait_clk(4);
        scl = 1'b1; wait_clk(8);
        scl = 1'b0; wait_clk(4);
    endtask

    task automatic release_reset();
        card_rst = 1'b0; wait_clk(8);
    endtask

    task automatic clock_bits(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            exp_bit_t e;
            e.val = w[i];
            e.pos = i;
            exp_q.push_back(e);
        end
        for (int i = 0; i < n; i++) scl_pulse();
        check("R4 scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic full_stream(input logic [31:0] w, input string tag);
        int c0;
        atr_word = w;
        mon_tag  = tag;
        c0 = clr_count;
        reset_pulse();
        check("R1 one clear pulse", clr_count - c0, 1);
        check("R6 bus withdrawn", {31'd0, twi_enable}, 0);
        release_reset();
        clock_bits(w, 32);
        check("R5 line released", {31'd0, sda_oe}, 0);
        check("R6 bus returned", {31'd0, twi_enable}, 1);
    endtask

    initial begin
        wait_clk(3);
        check("R9 sda_oe", {31'd0, sda_oe}, 0);
        check("R9 priv_clear", {31'd0, priv_clear}, 0);
        check("R9 twi_enable", {31'd0, twi_enable}, 1);
        rst_n = 1'b1;
        wait_clk(4);

        // R2: reset level without an SCL pulse
        card_rst = 1'b1; wait_clk(40);
        check("R2 no clear", clr_count, 0);
        check("R2 line idle", {31'd0, sda_oe}, 0);
        check("R2 bus kept", {31'd0, twi_enable}, 1);
        card_rst = 1'b0; wait_clk(10);
        check("R2 no clear after drop", clr_count, 0);

        // R10: default word, plus R8 extra pulses while reset is high
        atr_word = ATR_DEFAULT_WORD;
        mon_tag  = "R10 default word";
        reset_pulse();
        check("R1 clear from idle", clr_count, 1);
        scl_pulse();
        scl_pulse();
        check("R8 no extra clear", clr_count, 1);
        check("R8 still holding", {31'd0, sda_oe}, 0);
        release_reset();
        clock_bits(ATR_DEFAULT_WORD, 32);
        check("R5 line released", {31'd0, sda_oe}, 0);
        check("R5 bus returned", {31'd0, twi_enable}, 1);

        // R5: pulses after the end keep the line released
        scl_pulse();
        scl_pulse();
        check("R5 idle after extra pulses", {31'd0, sda_oe}, 0);
        check("R5 no clear on plain pulses", clr_count, 1);

        full_stream(32'h12345678, "R4 pattern 12345678");
        full_stream(32'hFFFFFFFF, "R4 all ones");
        full_stream(32'h00000000, "R4 all zeros");

        // R7: restart mid-stream
        atr_word = 32'hDEADBEEF;
        mon_tag  = "R7 aborted stream";
        reset_pulse();
        release_reset();
        clock_bits(32'hDEADBEEF, 10);
        check("R6 bus held mid-stream", {31'd0, twi_enable}, 0);
        full_stream(32'h0F0F3C5A, "R7 restarted stream");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule